// File: doc/BRIEF.md
# Selectable-Polynomial Serial CRC Engine

This block computes a frame check on a transparent serial channel, one bit per clock whenever the bit-enable strobe is high. A 2-bit mode picks the check at the start of each frame. The choices are a 16-bit CCITT check, a 16-bit BISYNC-style CRC16 and a 32-bit check. One more code is reserved and is rejected.

In transmit direction, bytes are loaded one at a time and serialized, either least-significant bit first or, when the reverse control is set, most-significant bit first. Every line bit feeds the CRC register. At frame end the engine may append the check, depending on an append flag sampled at frame start. The check goes out one bit per enable, MSB of the register first.

In receive direction, line bits are shifted in and packed into bytes in the same order convention. At frame end the register is compared with the fixed residue of the active mode, and the result is left in a status bit. A mismatch never blocks reception, so software may ignore it.

Top module: `serial_crc_unit`

## Requirements
- R1: Mode code 2'b00 uses polynomial x^16+x^12+x^5+1 (0x1021), with the register preset to 0xFFFF at frame start. The check is sent as the ones complement of the register.
- R2: Mode code 2'b01 uses polynomial x^16+x^15+x^2+1 (0x8005), with the register preset to 0x0000. The check is sent uncomplemented.
- R3: Mode code 2'b10 uses the 32-bit polynomial 0x04C11DB7, with the register preset to 0xFFFFFFFF. The check is sent complemented.
- R4: Mode code 2'b11 is reserved. It raises cfgErr from the cycle after frameStart until the next frameStart. No check bits are sent, done pulses in the cycle after frameEnd, and crcErr stays 0.
- R5: On transmit with revData=1, each loaded byte appears on serOut bit 7 first. With revData=0 it appears bit 0 first. One bit is consumed per bitEn cycle.
- R6: On receive, serIn bits are packed into rxByte. The first bit lands in bit 7 when revData=1 and in bit 0 when revData=0. rxByteValid pulses for one cycle after every eighth bit, check bits included.
- R7: The append flag is sampled at frameStart. With it clear, no check is sent and done pulses in the cycle after frameEnd.
- R8: With append set and a valid mode, the check follows frameEnd MSB first, 16 or 32 bits, one per bitEn. done pulses for exactly one cycle after the edge that consumes the last check bit.
- R9: On receive, at frameEnd the register is compared with 0x1D0F (mode 00), 0x0000 (mode 01) or 0xC704DD7B (mode 10). crcErr is set on a mismatch and held until the next frameStart, while bytes keep being delivered.
- R10: Changes to modeSel, revData or appendChk after frameStart have no effect on the current frame.
- R11: After reset, serOut, rxByteValid, crcErr, cfgErr and done are all 0.
- R12: While bitEn is low, serOut holds its value and no bit is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitEn | input | 1 | Consume or produce one line bit this cycle |
| frameStart | input | 1 | Start a frame; samples the configuration and presets the register |
| frameEnd | input | 1 | End of the frame's data bits |
| txDir | input | 1 | 1 = transmit, 0 = receive (sampled at frameStart) |
| modeSel | input | 2 | Check type code (sampled at frameStart) |
| revData | input | 1 | 1 = MSB first per byte (sampled at frameStart) |
| appendChk | input | 1 | Append the check on transmit (sampled at frameStart) |
| byteLoad | input | 1 | Load byteIn into the transmit shifter |
| byteIn | input | 8 | Transmit byte |
| serIn | input | 1 | Receive line bit |
| serOut | output | 1 | Transmit line bit |
| rxByte | output | 8 | Assembled receive byte |
| rxByteValid | output | 1 | rxByte complete (one-cycle pulse) |
| crcErr | output | 1 | Receive check mismatch status |
| cfgErr | output | 1 | Reserved mode selected for this frame |
| done | output | 1 | Frame finished (one-cycle pulse) |

## Verification
The assertions take some things about the inputs for granted. frameStart and frameEnd are single-cycle pulses, bitEn is never high in a frameStart or frameEnd cycle, and byteLoad only comes when all eight bits of the previous byte have been consumed. The status hold checks rely on frameStart and frameEnd being the only events that may move the status bits. The bench drives every input at the falling edge and keeps to these rules: each byte load and each frame marker sits in a cycle of its own, with bitEn low.

// File: rtl/serial_crc_pkg.sv
package serial_crc_pkg;

  typedef enum logic [1:0] {
    MODE_CCITT = 2'b00,
    MODE_CRC16 = 2'b01,
    MODE_CRC32 = 2'b10,
    MODE_RSVD  = 2'b11
  } crcMode_e;

  typedef struct packed {
    logic preset;
    logic loadByte;
    logic shiftData;
    logic loadCheck;
    logic shiftCheck;
    logic evalRx;
    logic dataPhase;
    logic checkPhase;
  } ctlStrobe_t;

  localparam int CRC_W = 32;

  function automatic logic [CRC_W-1:0] polyOf(crcMode_e m);
    case (m)
      MODE_CCITT: polyOf = 32'h0000_1021;
      MODE_CRC16: polyOf = 32'h0000_8005;
      MODE_CRC32: polyOf = 32'h04C1_1DB7;
      default:    polyOf = '0;
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] presetOf(crcMode_e m);
    case (m)
      MODE_CCITT: presetOf = 32'h0000_FFFF;
      MODE_CRC32: presetOf = 32'hFFFF_FFFF;
      default:    presetOf = '0;
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] xorOutOf(crcMode_e m);
    case (m)
      MODE_CCITT: xorOutOf = 32'h0000_FFFF;
      MODE_CRC32: xorOutOf = 32'hFFFF_FFFF;
      default:    xorOutOf = '0;
    endcase
  endfunction

  function automatic logic [CRC_W-1:0] residueOf(crcMode_e m);
    case (m)
      MODE_CCITT: residueOf = 32'h0000_1D0F;
      MODE_CRC32: residueOf = 32'hC704_DD7B;
      default:    residueOf = '0;
    endcase
  endfunction

endpackage

// File: rtl/serial_crc_ctrl.sv
module serial_crc_ctrl
  import serial_crc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       frameStart,
  input  logic       frameEnd,
  input  logic       byteLoad,
  input  logic       txDir,
  input  logic       appendChk,
  input  logic [1:0] modeSel,
  output ctlStrobe_t stb,
  output logic       done
);

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_CHECK} ctlState_e;

  localparam int CNT_W = $clog2(CRC_W + 1);

  ctlState_e  state;
  logic       appendQ;
  logic       txQ;
  logic       wideQ;
  logic [CNT_W-1:0] chkCnt;
  crcMode_e   modeIn;

  assign modeIn = crcMode_e'(modeSel);

  always_comb begin
    stb            = '0;
    stb.preset     = frameStart;
    stb.dataPhase  = (state == ST_DATA);
    stb.checkPhase = (state == ST_CHECK);
    stb.loadByte   = byteLoad && (state == ST_DATA);
    stb.shiftData  = bitEn && (state == ST_DATA);
    stb.loadCheck  = frameEnd && (state == ST_DATA) && appendQ;
    stb.shiftCheck = bitEn && (state == ST_CHECK);
    stb.evalRx     = frameEnd && (state == ST_DATA) && !txQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      appendQ <= 1'b0;
      txQ     <= 1'b0;
      wideQ   <= 1'b0;
      chkCnt  <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (frameStart) begin
        state   <= ST_DATA;
        txQ     <= txDir;
        wideQ   <= (modeIn == MODE_CRC32);
        appendQ <= appendChk && txDir && (modeIn != MODE_RSVD);
      end else begin
        case (state)
          ST_DATA: if (frameEnd) begin
            if (appendQ) begin
              state  <= ST_CHECK;
              chkCnt <= wideQ ? CNT_W'(32) : CNT_W'(16);
            end else begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
          ST_CHECK: if (bitEn) begin
            chkCnt <= chkCnt - 1'b1;
            if (chkCnt == CNT_W'(1)) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/serial_crc_dpath.sv
module serial_crc_dpath
  import serial_crc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [1:0]        modeSel,
  input  logic              revData,
  input  logic              txDir,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              serIn,
  output logic              serOut,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxByteValid,
  output logic              crcErr,
  output logic              cfgErr
);

  localparam int BCNT_W = $clog2(BYTE_W);
  localparam logic [BCNT_W-1:0] BIT_LAST = BCNT_W'(BYTE_W - 1);

  crcMode_e          modeQ;
  logic              revQ;
  logic              txQ;
  logic              wideQ;
  logic [CRC_W-1:0]  crcQ;
  logic [CRC_W-1:0]  outQ;
  logic [BYTE_W-1:0] shQ;
  logic [BCNT_W-1:0] bitCnt;

  logic             txBit, lineBit, topBit, fb;
  logic [CRC_W-1:0] crcShift, crcNext, chkVal;
  crcMode_e         modeIn;

  assign modeIn   = crcMode_e'(modeSel);
  assign txBit    = revQ ? shQ[BYTE_W-1] : shQ[0];
  assign lineBit  = txQ ? txBit : serIn;
  assign topBit   = wideQ ? crcQ[CRC_W-1] : crcQ[15];
  assign fb       = topBit ^ lineBit;
  assign crcShift = {crcQ[CRC_W-2:0], 1'b0} ^ (fb ? polyOf(modeQ) : '0);
  assign crcNext  = wideQ ? crcShift : {16'h0, crcShift[15:0]};
  assign chkVal   = crcQ ^ xorOutOf(modeQ);

  assign serOut = stb.checkPhase ? outQ[CRC_W-1]
                : (stb.dataPhase && txQ) ? txBit : 1'b0;
  assign rxByte = shQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ       <= MODE_CCITT;
      revQ        <= 1'b0;
      txQ         <= 1'b0;
      wideQ       <= 1'b0;
      crcQ        <= '0;
      outQ        <= '0;
      shQ         <= '0;
      bitCnt      <= '0;
      rxByteValid <= 1'b0;
      crcErr      <= 1'b0;
      cfgErr      <= 1'b0;
    end else if (stb.preset) begin
      modeQ       <= modeIn;
      revQ        <= revData;
      txQ         <= txDir;
      wideQ       <= (modeIn == MODE_CRC32);
      crcQ        <= presetOf(modeIn);
      outQ        <= '0;
      shQ         <= '0;
      bitCnt      <= '0;
      rxByteValid <= 1'b0;
      crcErr      <= 1'b0;
      cfgErr      <= (modeIn == MODE_RSVD);
    end else begin
      rxByteValid <= 1'b0;
      if (stb.loadByte && txQ) shQ <= byteIn;
      if (stb.shiftData) begin
        crcQ   <= crcNext;
        bitCnt <= (bitCnt == BIT_LAST) ? '0 : bitCnt + 1'b1;
        if (txQ) begin
          shQ <= revQ ? {shQ[BYTE_W-2:0], 1'b0} : {1'b0, shQ[BYTE_W-1:1]};
        end else begin
          shQ <= revQ ? {shQ[BYTE_W-2:0], serIn} : {serIn, shQ[BYTE_W-1:1]};
          if (bitCnt == BIT_LAST) rxByteValid <= 1'b1;
        end
      end
      if (stb.loadCheck) outQ <= wideQ ? chkVal : {chkVal[15:0], 16'h0};
      if (stb.shiftCheck) outQ <= {outQ[CRC_W-2:0], 1'b0};
      if (stb.evalRx) crcErr <= (modeQ != MODE_RSVD) && (crcQ != residueOf(modeQ));
    end
  end

endmodule

// File: rtl/serial_crc_unit.sv
module serial_crc_unit
  import serial_crc_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic              frameStart,
  input  logic              frameEnd,
  input  logic              txDir,
  input  logic [1:0]        modeSel,
  input  logic              revData,
  input  logic              appendChk,
  input  logic              byteLoad,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              serIn,
  output logic              serOut,
  output logic [BYTE_W-1:0] rxByte,
  output logic              rxByteValid,
  output logic              crcErr,
  output logic              cfgErr,
  output logic              done
);

  ctlStrobe_t ctlStb;

  serial_crc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameStart(frameStart),
    .frameEnd(frameEnd), .byteLoad(byteLoad), .txDir(txDir),
    .appendChk(appendChk), .modeSel(modeSel), .stb(ctlStb), .done(done)
  );

  serial_crc_dpath #(.BYTE_W(BYTE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .modeSel(modeSel),
    .revData(revData), .txDir(txDir), .byteIn(byteIn), .serIn(serIn),
    .serOut(serOut), .rxByte(rxByte), .rxByteValid(rxByteValid),
    .crcErr(crcErr), .cfgErr(cfgErr)
  );

endmodule

// File: rtl/serial_crc_checker.sv
module serial_crc_checker (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic frameStart,
  input logic frameEnd,
  input logic done,
  input logic cfgErr,
  input logic crcErr,
  input logic rxByteValid,
  input logic checkPhase
);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !frameStart |=> $stable(cfgErr));

  assert_rsvd_no_check_R4: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> !checkPhase);

  assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(frameStart || frameEnd) |=> $stable(crcErr));

  assert_rx_byte_after_bit_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxByteValid |-> $past(bitEn));

endmodule

bind serial_crc_unit serial_crc_checker u_serial_crc_checker (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameStart(frameStart),
  .frameEnd(frameEnd), .done(done), .cfgErr(cfgErr), .crcErr(crcErr),
  .rxByteValid(rxByteValid), .checkPhase(ctlStb.checkPhase)
);

// File: tb/serial_crc_unit_bench.sv
module serial_crc_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitEn = 1'b0, frameStart = 1'b0, frameEnd = 1'b0, txDir = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic       revData = 1'b0, appendChk = 1'b0, byteLoad = 1'b0, serIn = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic       serOut, rxByteValid, crcErr, cfgErr, done;
  logic [7:0] rxByte;

  int checks = 0;
  int errors = 0;

  logic [7:0] frameBytes [0:15];
  logic       lineBits [0:255];
  int         nBits;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_crc_unit u_serial_crc_unit (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .frameStart(frameStart),
    .frameEnd(frameEnd), .txDir(txDir), .modeSel(modeSel), .revData(revData),
    .appendChk(appendChk), .byteLoad(byteLoad), .byteIn(byteIn), .serIn(serIn),
    .serOut(serOut), .rxByte(rxByte), .rxByteValid(rxByteValid),
    .crcErr(crcErr), .cfgErr(cfgErr), .done(done)
  );

  task automatic chkEq(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int widthOf(input int mode);
    return (mode == 2) ? 32 : 16;
  endfunction

  function automatic logic [31:0] refCrc(input int mode, input int cnt);
    logic [31:0] r, p, m;
    int w;
    w = widthOf(mode);
    p = (mode == 0) ? 32'h1021 : (mode == 1) ? 32'h8005 : 32'h04C11DB7;
    m = (w == 32) ? 32'hFFFFFFFF : 32'h0000FFFF;
    r = (mode == 1) ? 32'h0 : m;
    for (int i = 0; i < cnt; i++) begin
      logic f;
      f = r[w-1] ^ lineBits[i];
      r = ((r << 1) ^ (f ? p : 32'h0)) & m;
    end
    return r;
  endfunction

  function automatic logic [31:0] refXor(input int mode);
    return (mode == 0) ? 32'hFFFF : (mode == 2) ? 32'hFFFFFFFF : 32'h0;
  endfunction

  function automatic string modeReq(input int mode);
    return (mode == 0) ? "R1" : (mode == 1) ? "R2" : (mode == 2) ? "R3" : "R4";
  endfunction

  task automatic resetCheck();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chkEq("R11", "serOut", 32'(serOut), 0);
    chkEq("R11", "done", 32'(done), 0);
    chkEq("R11", "crcErr", 32'(crcErr), 0);
    chkEq("R11", "cfgErr", 32'(cfgErr), 0);
    chkEq("R11", "rxByteValid", 32'(rxByteValid), 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic startFrame(input int mode, input bit rev, input bit app, input bit tx);
    modeSel = 2'(mode); revData = rev; appendChk = app; txDir = tx;
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  task automatic txFrame(input int mode, input bit rev, input bit app, input int n,
                         input bit midChange, input bit pause);
    logic [31:0] chk;
    int w;
    startFrame(mode, rev, app, 1'b1);
    chkEq("R4", "cfgErr tx", 32'(cfgErr), 32'(mode == 3));
    if (midChange) begin
      modeSel = (mode == 2) ? 2'b00 : 2'b10;
      revData = !rev;
      appendChk = !app;
    end
    nBits = 0;
    for (int b = 0; b < n; b++) begin
      byteIn = frameBytes[b]; byteLoad = 1'b1;
      @(negedge clk);
      byteLoad = 1'b0;
      for (int k = 0; k < 8; k++) begin
        logic e;
        e = rev ? frameBytes[b][7-k] : frameBytes[b][k];
        lineBits[nBits] = e; nBits++;
        chkEq(midChange ? "R10" : "R5", "serOut data bit", 32'(serOut), 32'(e));
        if (pause && k == 3) begin
          bitEn = 1'b0;
          @(negedge clk);
          chkEq("R12", "serOut held while idle", 32'(serOut), 32'(e));
        end
        bitEn = 1'b1;
        @(negedge clk);
        bitEn = 1'b0;
      end
    end
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
    if (app && mode != 3) begin
      w = widthOf(mode);
      chk = refCrc(mode, nBits) ^ refXor(mode);
      for (int i = 0; i < w; i++) begin
        chkEq(modeReq(mode), "check bit", 32'(serOut), 32'(chk[w-1-i]));
        chkEq("R8", "done before last", 32'(done), 0);
        bitEn = 1'b1;
        @(negedge clk);
        bitEn = 1'b0;
      end
      chkEq("R8", "done after last check bit", 32'(done), 1);
    end else begin
      chkEq(mode == 3 ? "R4" : "R7", "done right after frameEnd", 32'(done), 1);
      chkEq(mode == 3 ? "R4" : "R7", "no check bit driven", 32'(serOut), 0);
    end
    @(negedge clk);
    chkEq("R8", "done single cycle", 32'(done), 0);
    chkEq("R4", "cfgErr held", 32'(cfgErr), 32'(mode == 3));
  endtask

  task automatic rxFrame(input int mode, input bit rev, input int n, input bit corrupt);
    logic [31:0] chk;
    int w;
    nBits = 0;
    for (int b = 0; b < n; b++)
      for (int k = 0; k < 8; k++) begin
        lineBits[nBits] = rev ? frameBytes[b][7-k] : frameBytes[b][k];
        nBits++;
      end
    if (mode != 3) begin
      w = widthOf(mode);
      chk = refCrc(mode, nBits) ^ refXor(mode);
      for (int i = 0; i < w; i++) begin
        lineBits[nBits] = chk[w-1-i]; nBits++;
      end
    end
    if (corrupt) lineBits[3] = !lineBits[3];
    startFrame(mode, rev, 1'b0, 1'b0);
    for (int i = 0; i < nBits; i++) begin
      serIn = lineBits[i]; bitEn = 1'b1;
      @(negedge clk);
      bitEn = 1'b0;
      chkEq("R6", "rxByteValid", 32'(rxByteValid), 32'((i % 8) == 7));
      if ((i % 8) == 7) begin
        logic [7:0] e;
        for (int k = 0; k < 8; k++) begin
          if (rev) e[7-k] = lineBits[i-7+k];
          else     e[k]   = lineBits[i-7+k];
        end
        chkEq(corrupt ? "R9" : "R6", "rxByte", 32'(rxByte), 32'(e));
      end
    end
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
    chkEq(mode == 3 ? "R4" : "R9", "crcErr", 32'(crcErr), 32'(corrupt && mode != 3));
    chkEq("R9", "done rx", 32'(done), 1);
    @(negedge clk);
    chkEq("R9", "crcErr held", 32'(crcErr), 32'(corrupt && mode != 3));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) frameBytes[i] = 8'(8'h31 + i * 8'h17);
    @(negedge clk);
    resetCheck();
    txFrame(0, 1'b0, 1'b1, 3, 1'b0, 1'b0);
    txFrame(1, 1'b1, 1'b1, 2, 1'b0, 1'b1);
    txFrame(2, 1'b0, 1'b1, 4, 1'b1, 1'b0);
    txFrame(0, 1'b1, 1'b0, 2, 1'b0, 1'b0);
    txFrame(3, 1'b0, 1'b1, 1, 1'b0, 1'b0);
    rxFrame(0, 1'b0, 3, 1'b0);
    rxFrame(1, 1'b1, 2, 1'b0);
    rxFrame(2, 1'b0, 4, 1'b1);
    rxFrame(2, 1'b1, 3, 1'b0);
    rxFrame(0, 1'b1, 2, 1'b1);
    rxFrame(3, 1'b0, 2, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule